// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Delay Timer

This block derives the serial clock of an SPI master and the two chip-select guard delays from the system clock. Each interval is the product of two factors: a small prescaler picked by a 2-bit code and a scaler picked by a 4-bit code. A frame engine sits beside it and holds the codes. That engine starts and stops the serial clock and triggers the delay it needs. In return it receives single-cycle strobes on every clock edge and a single-cycle done pulse when a delay runs out.

The serial clock divisor is the baud prescaler value times the baud scaler value. After a start the clock idles low for the first half-period. It then alternates high and low phases, and each strobe coincides with the change of level. There are two delay channels: chip-select to first clock edge, and last clock edge to chip-select release. Each channel counts its prescaler value times a power of two set by its scaler code. Every channel takes its codes at its own start, so a code change during a count has no effect on that count.

Top module: `spi_clk_timer`

## Requirements
- R1: Baud prescaler code 0, 1, 2, 3 selects factor 2, 3, 5, 7.
- R2: Baud scaler code 0..3 selects 2, 4, 6, 8. Code k from 4 to 15 selects 2^k (16 up to 32768).
- R3: While sck_run_i is high, sck_o has period N = prescaler × scaler. The first rising strobe comes floor(N/2) cycles after the clock edge that samples sck_run_i rising. Each high phase lasts N - floor(N/2) cycles and each low phase floor(N/2) cycles.
- R4: sck_rise_o is high for one cycle, in the cycle where sck_o first reads 1. sck_fall_o is high for one cycle, in the cycle where sck_o first reads 0. The two are never high together.
- R5: The baud codes are sampled only on the edge that starts the clock. Changing them while the clock runs leaves the period unchanged.
- R6: One cycle after sck_run_i is sampled low, sck_o is 0 and neither edge strobe fires, even if sck_o was high.
- R7: A delay channel raises its done output D cycles after the edge that samples its start. D = P × 2^(S+1), where delay prescaler code 0..3 gives P = 1, 3, 5, 7 and S is the 4-bit scaler code.
- R8: A done output is high for exactly one cycle per expired count.
- R9: A start while a count runs restarts the count with the codes present at that start. Code changes between starts do not alter a running count.
- R10: The chip-select-to-clock channel and the after-clock channel count independently when started together.
- R11: After reset, sck_o, both edge strobes and both done outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_run_i | input | 1 | Run the serial clock while high |
| baud_pre_i | input | 2 | Baud prescaler code |
| baud_scl_i | input | 4 | Baud scaler code |
| sck_o | output | 1 | Serial clock, idle low |
| sck_rise_o | output | 1 | Strobe in the cycle sck_o goes high |
| sck_fall_o | output | 1 | Strobe in the cycle sck_o goes low |
| lead_start_i | input | 1 | Start the chip-select-to-clock delay |
| lead_pre_i | input | 2 | Lead delay prescaler code |
| lead_scl_i | input | 4 | Lead delay scaler code |
| lead_done_o | output | 1 | Lead delay expired (one cycle) |
| trail_start_i | input | 1 | Start the after-clock delay |
| trail_pre_i | input | 2 | Trail delay prescaler code |
| trail_scl_i | input | 4 | Trail delay scaler code |
| trail_done_o | output | 1 | Trail delay expired (one cycle) |

## Verification
A done pulse is due exactly D clock edges after the edge that captures its start. The first rising strobe is due floor(N/2) edges after the edge that captures sck_run_i rising. Each later strobe is due one phase length after the previous one. The bench drives every input on the falling clock edge and samples on falling edges, counting edges from the capture edge. Each result is compared against the number of edges expected for it. The sample after each done pulse and the sample after run is dropped are also checked, which confirms the pulse width and the stop behaviour.

// File: rtl/spi_clk_timer_pkg.sv
package spi_clk_timer_pkg;
  localparam int unsigned PRE_W = 2;
  localparam int unsigned SCL_W = 4;

  function automatic int unsigned baud_pre_val(logic [PRE_W-1:0] c);
    case (c)
      2'd0:    return 2;
      2'd1:    return 3;
      2'd2:    return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int unsigned baud_scl_val(logic [SCL_W-1:0] c);
    if (c < 4'd4) return (int'(c) + 1) * 2;
    return 32'd1 << c;
  endfunction

  function automatic int unsigned dly_pre_val(logic [PRE_W-1:0] c);
    return int'(c) * 2 + 1;
  endfunction
endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div
  import spi_clk_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_code_i,
  input  logic [SCL_W-1:0] scl_code_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] div_d, lo_d;
  logic [CNT_W-1:0] lo_q, hi_q, cnt_q;
  logic             active_q, sck_q, rise_q, fall_q;

  assign div_d = CNT_W'(baud_pre_val(pre_code_i) * baud_scl_val(scl_code_i));
  assign lo_d  = div_d >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      cnt_q    <= '0;
    end else if (!run_i) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      // codes captured here only
      active_q <= 1'b1;
      lo_q     <= lo_d;
      hi_q     <= div_d - lo_d;
      cnt_q    <= lo_d;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end else if (cnt_q == CNT_W'(1)) begin
      sck_q  <= ~sck_q;
      rise_q <= ~sck_q;
      fall_q <= sck_q;
      cnt_q  <= sck_q ? lo_q : hi_q;
    end else begin
      cnt_q  <= cnt_q - CNT_W'(1);
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  p_rise_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> sck_q);
  p_fall_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |-> !sck_q);
  p_one_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_q, fall_q}));
  p_stop_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!sck_q && !rise_q && !fall_q));
endmodule

// File: rtl/spi_dly_timer.sv
module spi_dly_timer
  import spi_clk_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PRE_W-1:0] pre_code_i,
  input  logic [SCL_W-1:0] scl_code_i,
  output logic             done_o
);
  logic [CNT_W-1:0] len_d, cnt_q;
  logic             busy_q, done_q;

  assign len_d = CNT_W'(dly_pre_val(pre_code_i) << (int'(scl_code_i) + 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= len_d;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q && cnt_q == CNT_W'(1)) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else begin
      cnt_q  <= busy_q ? cnt_q - CNT_W'(1) : cnt_q;
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_start_restarts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_q);
  p_done_ends_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
endmodule

// File: rtl/spi_clk_timer.sv
module spi_clk_timer
  import spi_clk_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 19,
  localparam int unsigned N_DLY = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_run_i,
  input  logic [1:0] baud_pre_i,
  input  logic [3:0] baud_scl_i,
  output logic       sck_o,
  output logic       sck_rise_o,
  output logic       sck_fall_o,
  input  logic       lead_start_i,
  input  logic [1:0] lead_pre_i,
  input  logic [3:0] lead_scl_i,
  output logic       lead_done_o,
  input  logic       trail_start_i,
  input  logic [1:0] trail_pre_i,
  input  logic [3:0] trail_scl_i,
  output logic       trail_done_o
);
  logic [N_DLY-1:0]            st;
  logic [N_DLY-1:0]            dn;
  logic [N_DLY-1:0][PRE_W-1:0] pre;
  logic [N_DLY-1:0][SCL_W-1:0] scl;

  assign st  = {trail_start_i, lead_start_i};
  assign pre = {trail_pre_i, lead_pre_i};
  assign scl = {trail_scl_i, lead_scl_i};

  spi_sck_div #(.CNT_W(CNT_W)) u_sck (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (sck_run_i),
    .pre_code_i (baud_pre_i),
    .scl_code_i (baud_scl_i),
    .sck_o      (sck_o),
    .rise_o     (sck_rise_o),
    .fall_o     (sck_fall_o)
  );

  for (genvar g = 0; g < N_DLY; g++) begin : g_dly
    spi_dly_timer #(.CNT_W(CNT_W)) u_dly (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (st[g]),
      .pre_code_i (pre[g]),
      .scl_code_i (scl[g]),
      .done_o     (dn[g])
    );
  end

  assign lead_done_o  = dn[0];
  assign trail_done_o = dn[1];
endmodule

// File: tb/tb_spi_clk_timer.sv
module tb_spi_clk_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [1:0] bpre = '0, lpre = '0, tpre = '0;
  logic [3:0] bscl = '0, lscl = '0, tscl = '0;
  logic lstart = 1'b0, tstart = 1'b0;
  logic sck, rise, fall, ldone, tdone;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_clk_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_run_i(run), .baud_pre_i(bpre), .baud_scl_i(bscl),
    .sck_o(sck), .sck_rise_o(rise), .sck_fall_o(fall),
    .lead_start_i(lstart), .lead_pre_i(lpre), .lead_scl_i(lscl), .lead_done_o(ldone),
    .trail_start_i(tstart), .trail_pre_i(tpre), .trail_scl_i(tscl), .trail_done_o(tdone)
  );

  // {pre code, scaler code, expected divisor}
  localparam int NB = 10;
  localparam int BVEC [NB][3] = '{
    '{0, 0, 4}, '{1, 0, 6}, '{2, 0, 10}, '{3, 0, 14}, '{1, 1, 12},
    '{1, 2, 18}, '{2, 1, 20}, '{3, 3, 56}, '{0, 4, 32}, '{3, 5, 224}};
  localparam int ND = 6;
  localparam int DVEC [ND][3] = '{
    '{0, 0, 2}, '{1, 0, 6}, '{2, 1, 20}, '{3, 2, 56}, '{0, 3, 16}, '{3, 4, 224}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_sck(input int p, input int s, input int n, input bit chg, input string req);
    int lat, hi, lo;
    bpre = 2'(p); bscl = 4'(s); run = 1'b1;
    @(negedge clk); lat = 1;
    while (!rise && lat < n + 4) begin
      if (chg && lat == 2) begin bpre = 2'd3; bscl = 4'd6; end
      @(negedge clk); lat++;
    end
    chk(lat - 1 == n / 2 && sck, {req, " first low"}, lat - 1, n / 2);
    hi = 0;
    do begin @(negedge clk); hi++; end while (!fall && hi < n + 4);
    chk(hi == n - n / 2 && !sck, {req, " high"}, hi, n - n / 2);
    lo = 0;
    do begin @(negedge clk); lo++; end while (!rise && lo < n + 4);
    chk(hi + lo == n, {req, " period"}, hi + lo, n);
    run = 1'b0;
    @(negedge clk);
    chk(!sck && !rise && !fall, "R6 stop", int'({sck, rise, fall}), 0);
  endtask

  task automatic run_dly(input int ch, input int p, input int s, input int d,
                         input bit chg, input string req);
    int lat;
    if (ch == 0) begin lpre = 2'(p); lscl = 4'(s); lstart = 1'b1; end
    else begin tpre = 2'(p); tscl = 4'(s); tstart = 1'b1; end
    @(negedge clk); lstart = 1'b0; tstart = 1'b0; lat = 1;
    while (!(ch == 0 ? ldone : tdone) && lat < d + 4) begin
      if (chg && lat == 2) begin
        lpre = 2'd3; lscl = 4'd4; tpre = 2'd3; tscl = 4'd4;
      end
      @(negedge clk); lat++;
    end
    chk(lat - 1 == d, req, lat - 1, d);
    @(negedge clk);
    chk(!(ch == 0 ? ldone : tdone), "R8 single pulse", 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!sck && !rise && !fall && !ldone && !tdone, "R11 reset", int'({sck, rise, fall, ldone, tdone}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sck && !ldone && !tdone, "R11 after release", int'({sck, ldone, tdone}), 0);

    for (int i = 0; i < NB; i++)
      run_sck(BVEC[i][0], BVEC[i][1], BVEC[i][2], 1'b0, "R1 R2 R3 R4");
    for (int i = 0; i < ND; i++)
      run_dly(i % 2, DVEC[i][0], DVEC[i][1], DVEC[i][2], 1'b0, "R7 delay");

    // R5: code change while running
    run_sck(1, 0, 6, 1'b1, "R5 codes held");
    // R3 large scaler code
    run_sck(0, 12, 8192, 1'b0, "R2 R3 large");

    // R6: stop while high
    bpre = 2'd0; bscl = 4'd1; run = 1'b1;
    while (!rise) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk(!sck, "R6 stop while high", int'(sck), 0);
    begin
      int edges = 0;
      for (int k = 0; k < 12; k++) begin @(negedge clk); edges += int'(rise) + int'(fall); end
      chk(edges == 0, "R6 no strobes", edges, 0);
    end

    // R9: code change mid count ignored
    run_dly(0, 1, 0, 6, 1'b1, "R9 codes held");
    run_dly(1, 2, 0, 10, 1'b1, "R9 codes held trail");
    // R9: restart while busy
    lpre = 2'd3; lscl = 4'd2; lstart = 1'b1;
    @(negedge clk); lstart = 1'b0;
    repeat (10) @(negedge clk);
    chk(!ldone, "R9 no early done", int'(ldone), 0);
    run_dly(0, 0, 0, 2, 1'b0, "R9 restart");
    begin
      int extra = 0;
      for (int k = 0; k < 60; k++) begin @(negedge clk); extra += int'(ldone); end
      chk(extra == 0, "R9 old count dropped", extra, 0);
    end

    // R10: both channels together
    lpre = 2'd1; lscl = 4'd0; tpre = 2'd2; tscl = 4'd1;
    lstart = 1'b1; tstart = 1'b1;
    @(negedge clk); lstart = 1'b0; tstart = 1'b0;
    begin
      int lat_l = -1, lat_t = -1;
      for (int k = 1; k < 30; k++) begin
        if (ldone && lat_l < 0) lat_l = k - 1;
        if (tdone && lat_t < 0) lat_t = k - 1;
        @(negedge clk);
      end
      chk(lat_l == 6, "R10 lead", lat_l, 6);
      chk(lat_t == 20, "R10 trail", lat_t, 20);
    end

    // R7 largest scaler code
    run_dly(1, 0, 15, 65536, 1'b0, "R7 max scaler");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule